// File: doc/BRIEF.md
# Multi-Mode Timer and PWM Unit

This block holds four timer subsystems that share one synchronous register port and otherwise run on their own. Software picks, per subsystem and at run time, one of three uses for a 16-bit counter: two unrelated 8-bit PWM generators built from its two halves, one 16-bit PWM generator, or a free-running counter that stamps its value when either of two capture pins rises. Each subsystem slows its counter with its own 8-bit prescaler.

Period and duty values are staged in shadow registers and reach the counter only when that counter wraps, so an update never chops a pulse. Capture events raise sticky flags that double as interrupt lines and are cleared by writing ones. Disabling a subsystem or changing its mode restarts its counter and prescaler from zero.

Top module: `multi_timer`

## Requirements
- R1: The register address is {subsystem[1:0], index[2:0]}. Index 0 is control (bit 0 enable, bits 2:1 mode with 0 = split 8-bit PWM, 1 = 16-bit PWM, 2 = capture, 3 = reserved which holds the counter and keeps the outputs low; bits 15:8 prescale setting). Index 1 is period and index 2 is duty (read back as written). Index 3 and 4 read the capture values of channel 0 and 1. Index 5 reads the flags in bits 1:0. All other indexes read 0. Reads are combinational from the address. Writes to index 3 and 4 have no effect.
- R2: In split mode the low and high counter halves count independently from 0 up to the low and high byte of the active period, then wrap to 0. The low half drives pwm_out[2s] and the high half drives pwm_out[2s+1].
- R3: In 16-bit PWM mode the full counter counts from 0 up to the 16-bit active period and drives pwm_out[2s]. pwm_out[2s+1] stays low.
- R4: The counter advances on every (prescale+1)-th clock. After the control write edge that enables a subsystem, the counter value after k further edges is floor(k/(prescale+1)) modulo the period length. If the prescale setting drops below the running prescale count, the counter advances on the next clock.
- R5: A PWM output is high while its counter is below its active duty value. Duty 0 keeps it low, and a duty value above the period keeps it high.
- R6: In capture mode the counter runs freely and wraps past 0xFFFF. A capture pin is synchronized by two flops and edge-detected. A pin that is high before edge j stores the counter value held after edge j+1 into its capture register at edge j+2.
- R7: A capture sets that channel's sticky flag, which also drives cap_irq[2s+c]. Writing 1 to a flag bit clears it. A capture in the same cycle as a clear leaves the flag set.
- R8: A period or duty write to a running subsystem reaches the counter only when that counter (or that half, in split mode) wraps. While the subsystem is disabled, the written values take effect directly.
- R9: Clearing enable drives both outputs low from the write edge on. Writing a different mode restarts the counter and prescaler at zero on the write edge. A control write that keeps the mode and the enable bit set does not restart the counter.
- R10: After reset all registers, flags and capture values are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Subsystem and register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| cap_in | input | 8 | Capture pins, two per subsystem |
| pwm_out | output | 8 | PWM outputs, two per subsystem |
| cap_irq | output | 8 | Sticky capture flags, two per subsystem |

## Verification
A write takes effect at the clock edge that samples it, and PWM levels follow the counter state after that edge. A capture becomes visible two edges after the pin is first sampled high. A wrap-aligned period or duty update appears one full period later. The bench drives inputs at the falling edge and advances a reference model at the rising edge using the inputs sampled there. It compares outputs at the next falling edge, and reads rdata one step after setting the address. The directed checks count output highs over windows whose length is a whole number of periods, so each expected count does not depend on the start phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_CAPT  = 2'd2,
    MODE_RSVD  = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_PER  = 3'd1;
  localparam logic [2:0] REG_DUTY = 3'd2;
  localparam logic [2:0] REG_CAP0 = 3'd3;
  localparam logic [2:0] REG_CAP1 = 3'd4;
  localparam logic [2:0] REG_FLAG = 3'd5;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [PS_W-1:0] div,
  output logic            tick
);
  logic [PS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = !clear && (cnt_q >= div);
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: with a nonzero setting, two ticks never come back to back
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], din};
    rise = sh_q[1] & ~sh_q[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // R6: one pin transition yields a single-cycle event
  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_slice.sv
module tmr_slice
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  tmr_mode_e             mode,
  input  logic                  restart,
  input  logic [PS_W-1:0]       ps,
  input  logic [CNT_W-1:0]      per_sh,
  input  logic [CNT_W-1:0]      duty_sh,
  input  logic [1:0]            cap_pin,
  input  logic [1:0]            flag_clr,
  output logic [1:0]            pwm,
  output logic [1:0][CNT_W-1:0] cap_val,
  output logic [1:0]            flags
);
  localparam int HALF = CNT_W / 2;

  logic                  kill, tick, cap_ok;
  logic [1:0]            rise, set_f;
  logic [CNT_W-1:0]      cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  logic [1:0][CNT_W-1:0] cap_q, cap_d;
  logic [1:0]            flg_q, flg_d;

  assign kill   = !en || restart;
  assign cap_ok = !kill && (mode == MODE_CAPT);

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(kill), .div(ps), .tick(tick)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cap
    tmr_edge_sync u_sync (.clk(clk), .rst_n(rst_n), .din(cap_pin[c]), .rise(rise[c]));
  end

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (kill) begin
      cnt_d  = '0;
      per_d  = per_sh;
      duty_d = duty_sh;
    end else if (tick) begin
      unique case (mode)
        MODE_SPLIT: begin
          for (int h = 0; h < 2; h++) begin
            if (cnt_q[h*HALF +: HALF] == per_q[h*HALF +: HALF]) begin
              cnt_d[h*HALF +: HALF]  = '0;
              per_d[h*HALF +: HALF]  = per_sh[h*HALF +: HALF];
              duty_d[h*HALF +: HALF] = duty_sh[h*HALF +: HALF];
            end else begin
              cnt_d[h*HALF +: HALF] = cnt_q[h*HALF +: HALF] + 1'b1;
            end
          end
        end
        MODE_WIDE: begin
          if (cnt_q == per_q) begin
            cnt_d  = '0;
            per_d  = per_sh;
            duty_d = duty_sh;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        MODE_CAPT: cnt_d = cnt_q + 1'b1;
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_comb begin
    set_f = cap_ok ? rise : 2'b00;
    cap_d = cap_q;
    for (int c = 0; c < 2; c++) begin
      if (set_f[c]) cap_d[c] = cnt_q;
    end
    flg_d = (flg_q & ~flag_clr) | set_f;
  end

  always_comb begin
    pwm = 2'b00;
    if (en) begin
      unique case (mode)
        MODE_SPLIT: begin
          for (int h = 0; h < 2; h++) begin
            pwm[h] = cnt_q[h*HALF +: HALF] < duty_q[h*HALF +: HALF];
          end
        end
        MODE_WIDE: pwm[0] = cnt_q < duty_q;
        default:   pwm = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      cap_q  <= '0;
      flg_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      cap_q  <= cap_d;
      flg_q  <= flg_d;
    end
  end

  assign cap_val = cap_q;
  assign flags   = flg_q;

  // R2: each half stays inside its active period
  p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_SPLIT) |->
      (cnt_q[HALF-1:0] <= per_q[HALF-1:0]) && (cnt_q[CNT_W-1:HALF] <= per_q[CNT_W-1:HALF]));
  // R3: the joined counter stays inside its active period
  p_wide_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_WIDE) |-> (cnt_q <= per_q));
  // R9: a disable or restart leaves the counter at zero
  p_kill_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (cnt_q == '0));
  // R6: a capture event stores the counter of the same cycle
  p_cap_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ok && rise[0]) |=> (cap_q[0] == $past(cnt_q)));
  // R7: a flag is kept until it is written with 1
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[1] && !flag_clr[1]) |=> flg_q[1]);
endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import tmr_pkg::*;
#(
  parameter int N_SUB = 4,
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(N_SUB)+2:0]   addr,
  input  logic [CNT_W-1:0]           wdata,
  output logic [CNT_W-1:0]           rdata,
  input  logic [2*N_SUB-1:0]         cap_in,
  output logic [2*N_SUB-1:0]         pwm_out,
  output logic [2*N_SUB-1:0]         cap_irq
);
  localparam int SUB_W  = $clog2(N_SUB);
  localparam int IDX_W  = 3;
  localparam int PS_LSB = 8;
  localparam int PAD_W  = PS_LSB - 3;

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic [SUB_W-1:0] sub_sel;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] rd_sub [N_SUB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign sub_sel = addr[IDX_W +: SUB_W];
  assign idx     = addr[IDX_W-1:0];

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    logic                  hit, restart;
    logic                  en_q, en_d;
    tmr_mode_e             mode_q, mode_d;
    logic [PS_W-1:0]       ps_q, ps_d;
    logic [CNT_W-1:0]      per_q, per_d, duty_q, duty_d;
    logic [1:0]            clr;
    logic [1:0][CNT_W-1:0] cap_val;
    logic [1:0]            flags;

    assign hit     = wr_en && (sub_sel == SUB_W'(g));
    assign restart = hit && (idx == REG_CTRL) && (wdata[2:1] != mode_q);
    assign clr     = (hit && idx == REG_FLAG) ? wdata[1:0] : 2'b00;

    always_comb begin
      en_d   = en_q;
      mode_d = mode_q;
      ps_d   = ps_q;
      per_d  = per_q;
      duty_d = duty_q;
      if (hit && idx == REG_CTRL) begin
        en_d   = wdata[0];
        mode_d = tmr_mode_e'(wdata[2:1]);
        ps_d   = wdata[PS_LSB +: PS_W];
      end
      if (hit && idx == REG_PER)  per_d  = wdata;
      if (hit && idx == REG_DUTY) duty_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
        en_q   <= 1'b0;
        mode_q <= MODE_SPLIT;
        ps_q   <= '0;
        per_q  <= '0;
        duty_q <= '0;
      end else begin
        en_q   <= en_d;
        mode_q <= mode_d;
        ps_q   <= ps_d;
        per_q  <= per_d;
        duty_q <= duty_d;
      end
    end

    tmr_slice #(.CNT_W(CNT_W), .PS_W(PS_W)) u_slice (
      .clk(clk), .rst_n(rst_core_n), .en(en_q), .mode(mode_q), .restart(restart),
      .ps(ps_q), .per_sh(per_q), .duty_sh(duty_q), .cap_pin(cap_in[2*g +: 2]),
      .flag_clr(clr), .pwm(pwm_out[2*g +: 2]), .cap_val(cap_val), .flags(flags)
    );

    assign cap_irq[2*g +: 2] = flags;

    always_comb begin
      unique case (idx)
        REG_CTRL: rd_sub[g] = CNT_W'({ps_q, {PAD_W{1'b0}}, mode_q, en_q});
        REG_PER:  rd_sub[g] = per_q;
        REG_DUTY: rd_sub[g] = duty_q;
        REG_CAP0: rd_sub[g] = cap_val[0];
        REG_CAP1: rd_sub[g] = cap_val[1];
        REG_FLAG: rd_sub[g] = CNT_W'(flags);
        default:  rd_sub[g] = '0;
      endcase
    end

    // R9: once enable is clear both outputs of the subsystem are low
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
      !en_q |-> (pwm_out[2*g +: 2] == 2'b00));
  end

  assign rdata = rd_sub[sub_sel];
endmodule

// File: tb/tb_multi_timer.sv
module tb_multi_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  cap_in = '0;
  logic [7:0]  pwm_out, cap_irq;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R10";

  logic        m_en   [4];
  logic [1:0]  m_mode [4];
  logic [7:0]  m_ps   [4];
  logic [7:0]  m_pre  [4];
  logic [15:0] m_psh  [4];
  logic [15:0] m_dsh  [4];
  logic [15:0] m_pa   [4];
  logic [15:0] m_da   [4];
  logic [15:0] m_cnt  [4];
  logic [15:0] m_cap  [4][2];
  logic [1:0]  m_flg  [4];
  logic [1:0]  m_s1   [4];
  logic [1:0]  m_s2   [4];
  logic [1:0]  m_s3   [4];

  multi_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out), .cap_irq(cap_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(input logic en, input logic [1:0] md, input logic [7:0] ps);
    return {ps, 5'b0, md, en};
  endfunction

  function automatic logic [7:0] exp_pwm();
    logic [7:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      if (m_en[s]) begin
        if (m_mode[s] == 2'd0) begin
          r[2*s]   = m_cnt[s][7:0] < m_da[s][7:0];
          r[2*s+1] = m_cnt[s][15:8] < m_da[s][15:8];
        end else if (m_mode[s] == 2'd1) begin
          r[2*s] = m_cnt[s] < m_da[s];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    for (int s = 0; s < 4; s++) r[2*s +: 2] = m_flg[s];
    return r;
  endfunction

  function automatic logic [15:0] exp_read(input int s, input logic [2:0] ix);
    case (ix)
      3'd0: return {m_ps[s], 5'b0, m_mode[s], m_en[s]};
      3'd1: return m_psh[s];
      3'd2: return m_dsh[s];
      3'd3: return m_cap[s][0];
      3'd4: return m_cap[s][1];
      3'd5: return {14'b0, m_flg[s]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      m_en[s] = 0; m_mode[s] = 0; m_ps[s] = 0; m_pre[s] = 0;
      m_psh[s] = 0; m_dsh[s] = 0; m_pa[s] = 0; m_da[s] = 0; m_cnt[s] = 0;
      m_cap[s][0] = 0; m_cap[s][1] = 0; m_flg[s] = 0;
      m_s1[s] = 0; m_s2[s] = 0; m_s3[s] = 0;
    end
  endtask

  task automatic model_edge();
    for (int s = 0; s < 4; s++) begin
      logic sel, rst, kill, tick;
      logic [2:0] ix;
      logic [1:0] rise, setf, clr;
      logic [15:0] nc, np, nd;
      sel  = wr_en && (addr[4:3] == s[1:0]);
      ix   = addr[2:0];
      rst  = sel && ix == 3'd0 && (wdata[2:1] != m_mode[s]);
      kill = !m_en[s] || rst;
      rise = m_s2[s] & ~m_s3[s];
      tick = !kill && (m_pre[s] >= m_ps[s]);
      nc = m_cnt[s]; np = m_pa[s]; nd = m_da[s];
      if (kill) begin
        nc = 0; np = m_psh[s]; nd = m_dsh[s];
      end else if (tick) begin
        case (m_mode[s])
          2'd0: for (int h = 0; h < 2; h++) begin
            if (m_cnt[s][h*8 +: 8] == m_pa[s][h*8 +: 8]) begin
              nc[h*8 +: 8] = 0;
              np[h*8 +: 8] = m_psh[s][h*8 +: 8];
              nd[h*8 +: 8] = m_dsh[s][h*8 +: 8];
            end else nc[h*8 +: 8] = m_cnt[s][h*8 +: 8] + 8'd1;
          end
          2'd1: if (m_cnt[s] == m_pa[s]) begin
            nc = 0; np = m_psh[s]; nd = m_dsh[s];
          end else nc = m_cnt[s] + 16'd1;
          2'd2: nc = m_cnt[s] + 16'd1;
          default: ;
        endcase
      end
      setf = (!kill && m_mode[s] == 2'd2) ? rise : 2'b00;
      clr  = (sel && ix == 3'd5) ? wdata[1:0] : 2'b00;
      for (int c = 0; c < 2; c++) if (setf[c]) m_cap[s][c] = m_cnt[s];
      m_flg[s] = (m_flg[s] & ~clr) | setf;
      m_pre[s] = (kill || tick) ? 8'd0 : m_pre[s] + 8'd1;
      m_cnt[s] = nc; m_pa[s] = np; m_da[s] = nd;
      m_s3[s] = m_s2[s]; m_s2[s] = m_s1[s]; m_s1[s] = cap_in[2*s +: 2];
      if (sel && ix == 3'd0) begin
        m_en[s] = wdata[0]; m_mode[s] = wdata[2:1]; m_ps[s] = wdata[15:8];
      end
      if (sel && ix == 3'd1) m_psh[s] = wdata;
      if (sel && ix == 3'd2) m_dsh[s] = wdata;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(pwm_out == exp_pwm(), cur_req, "pwm_out", {8'h0, pwm_out}, {8'h0, exp_pwm()});
    check(cap_irq == exp_irq(), cur_req, "cap_irq", {8'h0, cap_irq}, {8'h0, exp_irq()});
  endtask

  task automatic wr(input int s, input logic [2:0] ix, input logic [15:0] d);
    wr_en = 1'b1; addr = {s[1:0], ix}; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic check_read(input int s, input logic [2:0] ix, input string req);
    addr = {s[1:0], ix};
    #1;
    check(rdata == exp_read(s, ix), req, "rdata", rdata, exp_read(s, ix));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int h0, h1, h2, h3, h4, h5;
    void'($urandom(32'h1A2B3C4D));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: quiet reset state
    cur_req = "R10";
    check(pwm_out == 8'h00, "R10", "pwm_out after reset", {8'h0, pwm_out}, 16'h0);
    check(cap_irq == 8'h00, "R10", "cap_irq after reset", {8'h0, cap_irq}, 16'h0);
    check_read(0, 3'd0, "R10");
    check_read(3, 3'd3, "R10");

    // R2 / R5: subsystem 0 split mode, high half duty above period
    cur_req = "R2";
    wr(0, 3'd1, {8'd9, 8'd5});
    wr(0, 3'd2, {8'd12, 8'd2});
    wr(0, 3'd0, ctrl(1'b1, 2'd0, 8'd0));
    // R4 / R5: subsystem 1 split mode with prescale 2, low duty 0
    cur_req = "R4";
    wr(1, 3'd1, 16'h0707);
    wr(1, 3'd2, 16'h0300);
    wr(1, 3'd0, ctrl(1'b1, 2'd0, 8'd2));
    h0 = 0; h1 = 0; h2 = 0; h3 = 0;
    for (int i = 0; i < 24; i++) begin
      step();
      h0 += pwm_out[0]; h1 += pwm_out[1]; h2 += pwm_out[2]; h3 += pwm_out[3];
    end
    check(h0 == 8, "R2", "low-half highs in 24", 16'(h0), 16'd8);
    check(h1 == 24, "R5", "duty above period highs", 16'(h1), 16'd24);
    check(h2 == 0, "R5", "duty zero highs", 16'(h2), 16'd0);
    check(h3 == 9, "R4", "prescaled highs from enable", 16'(h3), 16'd9);

    // R3: subsystem 2 joined mode, period 299, duty 100, prescale 1
    cur_req = "R3";
    wr(2, 3'd1, 16'd299);
    wr(2, 3'd2, 16'd100);
    wr(2, 3'd0, ctrl(1'b1, 2'd1, 8'd1));
    h4 = 0; h5 = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      h4 += pwm_out[4]; h5 += pwm_out[5];
    end
    check(h4 == 200, "R3", "16-bit highs per period", 16'(h4), 16'd200);
    check(h5 == 0, "R3", "second output in 16-bit mode", 16'(h5), 16'd0);

    // R8: new duty on a running split counter
    cur_req = "R8";
    wr(0, 3'd2, {8'd12, 8'd4});
    check_read(0, 3'd2, "R8");
    repeat (7) step();
    h0 = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      h0 += pwm_out[0];
    end
    check(h0 == 4, "R8", "updated duty highs", 16'(h0), 16'd4);

    // R6 / R7: subsystem 3 capture mode
    cur_req = "R6";
    wr(3, 3'd0, ctrl(1'b1, 2'd2, 8'd0));
    repeat (10) step();
    cap_in[6] = 1'b1;
    repeat (3) step();
    addr = {2'd3, 3'd3};
    #1;
    check(rdata == 16'd12, "R6", "captured count", rdata, 16'd12);
    check(cap_irq[6] == 1'b1, "R7", "flag after capture", {15'h0, cap_irq[6]}, 16'd1);
    cur_req = "R7";
    wr(3, 3'd5, 16'h0001);
    check(cap_irq[6] == 1'b0, "R7", "flag after clear", {15'h0, cap_irq[6]}, 16'd0);
    cap_in[7] = 1'b1;
    step();
    step();
    wr(3, 3'd5, 16'h0002);
    check(cap_irq[7] == 1'b1, "R7", "set wins over clear", {15'h0, cap_irq[7]}, 16'd1);
    check_read(3, 3'd5, "R7");

    // R1: capture registers ignore writes, control reads back
    cur_req = "R1";
    wr(3, 3'd3, 16'hFFFF);
    addr = {2'd3, 3'd3};
    #1;
    check(rdata == 16'd12, "R1", "capture after write", rdata, 16'd12);
    addr = {2'd1, 3'd0};
    #1;
    check(rdata == ctrl(1'b1, 2'd0, 8'd2), "R1", "control readback", rdata, ctrl(1'b1, 2'd0, 8'd2));
    check_read(1, 3'd7, "R1");

    // R9: disable and mode change
    cur_req = "R9";
    wr(0, 3'd0, ctrl(1'b0, 2'd0, 8'd0));
    check(pwm_out[1:0] == 2'b00, "R9", "outputs after disable", {14'h0, pwm_out[1:0]}, 16'd0);
    wr(2, 3'd0, ctrl(1'b1, 2'd0, 8'd1));
    check(pwm_out[5:4] == 2'b01, "R9", "outputs after mode change", {14'h0, pwm_out[5:4]}, 16'd1);
    repeat (20) step();
    wr(2, 3'd0, ctrl(1'b1, 2'd0, 8'd0));
    repeat (20) step();

    // R5: constrained random traffic against the model
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) begin
        int s;
        logic [2:0] ix;
        logic [15:0] d;
        s  = int'($urandom % 4);
        ix = 3'($urandom % 8);
        d  = 16'($urandom);
        if (ix == 3'd0) d = ctrl(($urandom % 4) != 0, 2'($urandom % 4), 8'($urandom % 4));
        else if (ix == 3'd1 || ix == 3'd2) d = d & 16'h1F1F;
        wr(s, ix, d);
      end else begin
        for (int b = 0; b < 8; b++) if (($urandom % 8) == 0) cap_in[b] = ~cap_in[b];
        step();
      end
      if ((i % 50) == 0) check_read(int'($urandom % 4), 3'($urandom % 8), "R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule